// File: doc/BRIEF.md
# Framed Stream Source with Overflow Flag

This block sits between a producer that emits one sample per cycle with no way to be held off and a consumer, usually a DMA engine, that takes data over an AXI4-Stream master port and may stall. Samples enter on a valid/data pair and are held in an internal first-in first-out buffer. The head of that buffer is offered on the stream port, and each beat is removed only when the consumer accepts it.

The accepted beats are grouped into frames of a fixed length set by a parameter. The last beat of every frame carries `tlast`. The frame position counts only accepted beats, so stalls on the output never shift a frame boundary.

The producer cannot be stopped. A sample that arrives while the buffer is full is therefore dropped, and a flag reports the drop in the same cycle. The buffer depth is a parameter. A depth that is a power of two uses plain wrapping pointers, and any other depth uses compare-and-wrap pointers.

Top module: `frame_stream_src`

## Requirements
- R1: Synchronous active-low reset empties the buffer and clears the frame position. In the first cycle after reset, `m_axis_tvalid` and `ovf` are low, and the first frame ends on its FRAME_LEN-th accepted beat.
- R2: Samples leave on `m_axis_tdata` in arrival order. Each accepted sample leaves exactly once, and no dropped sample ever leaves.
- R3: When `smp_valid` is high and the buffer holds DEPTH entries, the sample is discarded and `ovf` is high in that same cycle. `ovf` is low in every other cycle.
- R4: A sample that arrives while the buffer is full is dropped and flagged even if a beat is accepted in the same cycle. In that case the occupancy falls by one.
- R5: A beat transfers only in a cycle in which `m_axis_tvalid` and `m_axis_tready` are both high. While `m_axis_tvalid` is high and `m_axis_tready` is low, `m_axis_tvalid`, `m_axis_tdata` and `m_axis_tlast` hold their values into the next cycle.
- R6: `m_axis_tlast` is high on the beat whose index within its frame is FRAME_LEN-1, counting from 0. After that beat is accepted, the index returns to 0.
- R7: The frame index advances only on accepted beats. Input samples and stalled cycles leave it unchanged.
- R8: `m_axis_tvalid` is high exactly when the buffer is non-empty. A sample accepted into an empty buffer is offered in the cycle after its arrival edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Incoming sample present this cycle |
| smp_data | input | DATA_W | Incoming sample value |
| m_axis_tvalid | output | 1 | Stream beat offered |
| m_axis_tdata | output | DATA_W | Stream beat data (buffer head) |
| m_axis_tlast | output | 1 | Final beat of the current frame |
| m_axis_tready | input | 1 | Consumer accepts the offered beat |
| ovf | output | 1 | Incoming sample dropped because the buffer is full |

## Verification
The design is driven in several input patterns:
- A continuous stream with the consumer always ready shows the one-cycle fill latency, the arrival order and the frame boundaries when no stalls occur.
- A sparse input against a pseudo-random ready pattern separates a frame counter that counts handshakes from one that counts cycles or inputs, and it exposes data that moves during a stall.
- A run with the consumer held off fills the buffer and then overflows it, which checks the drop flag and checks that dropped values never reach the output.
- A write that arrives together with a read while the buffer is full shows whether a simultaneous read wrongly frees room for the write.
- A reset in the middle of a frame checks that the frame position restarts.

// File: rtl/fss_pkg.sv
// Package: shared helpers for the framed stream source.
// Assumes widths are derived by the modules that import it.
package fss_pkg;

    // Occupancy summary handed from the buffer to the handshake stage.
    typedef struct packed {
        logic empty;
        logic full;
    } buf_stat_t;

    // Counter width that stays legal for a modulus of 1.
    function automatic int unsigned cnt_width(input int unsigned modulus);
        return (modulus > 1) ? $clog2(modulus) : 1;
    endfunction

endpackage

// File: rtl/fss_buffer.sv
// Module: fss_buffer
// First-in first-out store for the sample stream. A write request while
// full is refused and reported on wr_drop, even when a read happens in the
// same cycle. A read request is honoured only when the store is non-empty.
// Assumes DEPTH >= 2. Any depth is allowed; a power of two uses plain wrap.
module fss_buffer
    import fss_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_req,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_req,
    output logic [DATA_W-1:0]          head_data,
    output buf_stat_t                  stat,
    output logic                       wr_drop,
    output logic [$clog2(DEPTH+1)-1:0] level
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = $clog2(DEPTH + 1);
    localparam bit          POW2 = ((1 << AW) == DEPTH);

    logic [DATA_W-1:0] store [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr, wr_ptr_nxt, rd_ptr_nxt;
    logic              wr_ok, rd_ok;

    // Qualify requests against current occupancy; full blocks the write
    // regardless of a simultaneous read.
    always_comb begin
        stat.empty = (level == '0);
        stat.full  = (level == LW'(DEPTH));
        wr_ok      = wr_req && !stat.full;
        rd_ok      = rd_req && !stat.empty;
        wr_drop    = wr_req && stat.full;
    end

    // Pointer advance: natural wrap for power-of-two depth, compare otherwise.
    generate
        if (POW2) begin : g_wrap_pow2
            always_comb begin
                wr_ptr_nxt = wr_ptr + 1'b1;
                rd_ptr_nxt = rd_ptr + 1'b1;
            end
        end else begin : g_wrap_cmp
            always_comb begin
                wr_ptr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
                rd_ptr_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
        end
    endgenerate

    // Storage write; contents need no reset because level gates visibility.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            store[wr_ptr] <= wr_data;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr_nxt;
            if (rd_ok) rd_ptr <= rd_ptr_nxt;
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Head of the store is presented directly.
    assign head_data = store[rd_ptr];

endmodule

// File: rtl/fss_frame_ctr.sv
// Module: fss_frame_ctr
// Tracks the index of the next beat within its frame. Advances only when
// step is high and wraps after index FRAME_LEN-1. A frame of one beat
// needs no state. Assumes FRAME_LEN >= 1.
module fss_frame_ctr
    import fss_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic at_last
);
    localparam int unsigned CW = cnt_width(FRAME_LEN);

    generate
        if (FRAME_LEN == 1) begin : g_single
            // Every beat closes its frame.
            assign at_last = 1'b1;
        end else begin : g_count
            logic [CW-1:0] idx;

            // Beat index, advanced on accepted beats only.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    idx <= '0;
                end else if (step) begin
                    idx <= (idx == CW'(FRAME_LEN - 1)) ? '0 : idx + 1'b1;
                end
            end

            // Flag the closing index of the frame.
            assign at_last = (idx == CW'(FRAME_LEN - 1));
        end
    endgenerate

endmodule

// File: rtl/fss_axis_hs.sv
// Module: fss_axis_hs
// Handshake stage: offers the buffer head whenever the buffer is non-empty
// and turns a completed handshake into a pop and a frame step. Holds no
// state; stability during a stall follows from the buffer's head staying put.
module fss_axis_hs
    import fss_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  buf_stat_t         stat,
    input  logic [DATA_W-1:0] head_data,
    input  logic              frame_end,
    input  logic              tready,
    output logic              tvalid,
    output logic [DATA_W-1:0] tdata,
    output logic              tlast,
    output logic              beat_done
);
    // Drive the stream outputs and detect the transfer.
    always_comb begin
        tvalid    = !stat.empty;
        tdata     = head_data;
        tlast     = tvalid && frame_end;
        beat_done = tvalid && tready;
    end

endmodule

// File: rtl/frame_stream_src.sv
// Module: frame_stream_src
// Bridges a non-stallable sample stream to an AXI4-Stream master with
// fixed-length frames. Samples are buffered; a sample arriving while the
// buffer is full is dropped and flagged on ovf in the same cycle.
// Assumes DEPTH >= 2 and FRAME_LEN >= 1; reset is synchronous, active low.
module frame_stream_src
    import fss_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned FRAME_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              m_axis_tvalid,
    output logic [DATA_W-1:0] m_axis_tdata,
    output logic              m_axis_tlast,
    input  logic              m_axis_tready,
    output logic              ovf
);
    localparam int unsigned LW = $clog2(DEPTH + 1);

    buf_stat_t         stat;
    logic [DATA_W-1:0] head_data;
    logic [LW-1:0]     fifo_level;
    logic              beat_done;
    logic              frame_end;

    // Sample store with drop detection.
    fss_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (smp_valid),
        .wr_data   (smp_data),
        .rd_req    (beat_done),
        .head_data (head_data),
        .stat      (stat),
        .wr_drop   (ovf),
        .level     (fifo_level)
    );

    // Position of the offered beat within its frame.
    fss_frame_ctr #(.FRAME_LEN(FRAME_LEN)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (beat_done),
        .at_last (frame_end)
    );

    // Stream handshake.
    fss_axis_hs #(.DATA_W(DATA_W)) u_hs (
        .stat      (stat),
        .head_data (head_data),
        .frame_end (frame_end),
        .tready    (m_axis_tready),
        .tvalid    (m_axis_tvalid),
        .tdata     (m_axis_tdata),
        .tlast     (m_axis_tlast),
        .beat_done (beat_done)
    );

endmodule

// File: rtl/frame_stream_src_chk.sv
// Module: frame_stream_src_chk
// Property checker bound to frame_stream_src. Keeps its own count of
// accepted beats to judge frame boundaries independently of the design.
module frame_stream_src_chk #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned FRAME_LEN = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       smp_valid,
    input logic                       m_axis_tvalid,
    input logic [DATA_W-1:0]          m_axis_tdata,
    input logic                       m_axis_tlast,
    input logic                       m_axis_tready,
    input logic                       ovf,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    localparam int unsigned LW = $clog2(DEPTH + 1);
    localparam int unsigned CW = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1;

    logic [CW-1:0] hs_seen;

    // Independent count of handshakes modulo the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_seen <= '0;
        end else if (m_axis_tvalid && m_axis_tready) begin
            hs_seen <= (hs_seen == CW'(FRAME_LEN - 1)) ? '0 : hs_seen + 1'b1;
        end
    end

    // R1: first cycle out of reset offers nothing.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !m_axis_tvalid && !ovf);

    // R3: a drop happens only with a sample present and the buffer full.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> smp_valid && (fifo_level == LW'(DEPTH)));

    // R3: occupancy never exceeds the depth.
    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(DEPTH));

    // R4: a dropped sample never adds to occupancy, even with a read.
    assert_drop_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> fifo_level == $past(fifo_level)
                 - LW'($past(m_axis_tvalid && m_axis_tready)));

    // R5: a stalled beat holds.
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        m_axis_tvalid && !m_axis_tready |=>
            m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast));

    // R6: tlast marks exactly the closing beat, by handshake count (R7).
    assert_last_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_axis_tvalid |-> (m_axis_tlast == (hs_seen == CW'(FRAME_LEN - 1))));

    // R8: an empty buffer offers no beat.
    assert_empty_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0) |-> !m_axis_tvalid);

endmodule

bind frame_stream_src frame_stream_src_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .FRAME_LEN(FRAME_LEN)
) u_chk (.*);

// File: tb/frame_stream_src_bench.sv
`timescale 1ns/1ps
// Bench: behavioural queue model compared with the design every cycle.
module frame_stream_src_bench;
    localparam int DATA_W    = 16;
    localparam int DEPTH     = 16;
    localparam int FRAME_LEN = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic              m_axis_tvalid, m_axis_tlast, ovf;
    logic [DATA_W-1:0] m_axis_tdata;
    logic              m_axis_tready = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [DATA_W-1:0] q[$];
    int                beat = 0;
    bit                prev_stall = 1'b0;
    logic [DATA_W-1:0] prev_data = '0;
    logic              prev_last = 1'b0;
    logic [DATA_W-1:0] seq = 16'h0100;
    logic [15:0]       lfsr = 16'hACE1;
    int                popped = 0;
    bit                seen_ovf = 1'b0;

    always #4 clk = ~clk;

    frame_stream_src #(.DATA_W(DATA_W), .DEPTH(DEPTH), .FRAME_LEN(FRAME_LEN))
    u_frame_stream_src (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .m_axis_tvalid(m_axis_tvalid), .m_axis_tdata(m_axis_tdata),
        .m_axis_tlast(m_axis_tlast), .m_axis_tready(m_axis_tready), .ovf(ovf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic cycle(input bit v, input bit r);
        bit exp_valid, exp_last, exp_ovf, full_now;
        @(negedge clk);
        smp_valid     = v;
        smp_data      = seq;
        m_axis_tready = r;
        #1;
        full_now  = (q.size() == DEPTH);
        exp_valid = (q.size() > 0);
        exp_last  = exp_valid && (beat == FRAME_LEN - 1);
        exp_ovf   = v && full_now;
        check(m_axis_tvalid === exp_valid, "R1/R8", "tvalid", m_axis_tvalid, exp_valid);
        if (exp_valid) begin
            check(m_axis_tdata === q[0], "R2", "tdata", m_axis_tdata, q[0]);
            check(m_axis_tlast === exp_last, "R6/R7", "tlast", m_axis_tlast, exp_last);
        end
        check(ovf === exp_ovf, "R3/R4", "ovf", ovf, exp_ovf);
        if (prev_stall) begin
            check(m_axis_tdata === prev_data && m_axis_tlast === prev_last,
                  "R5", "stalled beat", m_axis_tdata, prev_data);
        end
        if (ovf === 1'b1) seen_ovf = 1'b1;
        prev_stall = exp_valid && !r;
        prev_data  = m_axis_tdata;
        prev_last  = m_axis_tlast;
        if (exp_valid && r) begin
            void'(q.pop_front());
            beat = (beat + 1) % FRAME_LEN;
            popped++;
        end
        if (v && !full_now) q.push_back(seq);
        if (v) seq = seq + 16'h0013;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        m_axis_tready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        q.delete();
        beat = 0;
        prev_stall = 1'b0;
        #1;
        // R1: idle right after reset
        check(m_axis_tvalid === 1'b0, "R1", "tvalid after reset", m_axis_tvalid, 0);
        check(ovf === 1'b0, "R1", "ovf after reset", ovf, 0);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        do_reset();

        // R8 latency and R2 order, R6 boundaries: continuous flow.
        repeat (40) cycle(1'b1, 1'b1);
        repeat (4) cycle(1'b0, 1'b1);

        // R5 stall hold and R7 handshake-only counting: sparse input, random ready.
        for (int i = 0; i < 300; i++) begin
            step_lfsr();
            cycle(lfsr[0] & lfsr[3], lfsr[5] | lfsr[8]);
        end
        repeat (DEPTH + 2) cycle(1'b0, 1'b1);

        // R3: hold consumer off, overfill.
        seen_ovf = 1'b0;
        repeat (DEPTH + 5) cycle(1'b1, 1'b0);
        check(seen_ovf, "R3", "overflow seen", seen_ovf, 1);

        // R4: write together with read while full.
        seen_ovf = 1'b0;
        cycle(1'b1, 1'b1);
        check(seen_ovf, "R4", "drop with simultaneous read", seen_ovf, 1);
        popped = 0;
        repeat (DEPTH + 3) cycle(1'b0, 1'b1);
        check(popped == DEPTH - 1, "R4", "beats drained", popped, DEPTH - 1);

        // R1: reset mid-frame, then the frame restarts at index 0.
        repeat (3) cycle(1'b1, 1'b1);
        do_reset();
        repeat (2 * FRAME_LEN + 4) cycle(1'b1, 1'b1);
        repeat (4) cycle(1'b0, 1'b1);

        // Mixed burst with long stalls.
        for (int i = 0; i < 200; i++) begin
            step_lfsr();
            cycle(lfsr[1], lfsr[2] & lfsr[6]);
        end
        repeat (DEPTH + 2) cycle(1'b0, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule